// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block takes interrupt messages that arrive from the system bus. Each message names a target CPU and carries a 5-bit source identifier and two 64-bit payload words. Every CPU owns exactly one mailbox slot, and each slot has a busy flag. If the target slot is free, the message is accepted in the same cycle. The block then stores the source and both payload words, marks the slot busy, and one cycle later posts a single shared, software-programmable 6-bit vector to that CPU. If the target slot is busy, the message is refused and the sender has to try again later.

Software reaches the mailbox through a small register window. Each access carries the requesting CPU's number as a sideband signal. The window offers three kinds of access:
- Indexed views of the first payload word, the second payload word and the status of any slot.
- Three self-relative alias registers that select the slot of whichever CPU made the access.
- The shared vector register.

A CPU frees its slot by writing zero into the busy bit of a status register. Bus retry and interrupt delivery to the CPU sit outside this block.

Top module: `cpu_msg_mailbox`

## Requirements
- R1: After a synchronous reset, every slot is free with source 0, the shared vector is 0, and `post_valid` and `rd_valid` are low.
- R2: A valid message whose target slot is free raises `msg_accept` (and not `msg_refuse`) in the same cycle. Its source and both data words are stored, and the slot reads busy from the next cycle.
- R3: A valid message whose target slot is busy raises `msg_refuse` (and not `msg_accept`). It stores nothing, changes no slot, and produces no post.
- R4: One cycle after an acceptance, `post_valid` is high for one cycle, with `post_cpu` equal to the target CPU and `post_vec` equal to the shared vector at the time of acceptance.
- R5: A read request returns `rd_valid` and `rd_data` one cycle later. A status word holds busy in bit 5, the source ID in bits 4:0, and zero in all other bits.
- R6: Indexed registers use an 8-byte stride per CPU. The first payload word of CPU i is at 0x000+8*i, the second payload word at 0x100+8*i, and the status at 0x200+8*i.
- R7: Alias offsets 0x300 (payload word 0), 0x308 (payload word 1) and 0x310 (status) act on the slot numbered by `reg_cpu` of the same access.
- R8: A write to an indexed or alias status register loads busy from bit 5 of the write data. This can free or occupy a slot, and the stored source is left unchanged.
- R9: The shared vector register at 0x400 takes bits 5:0 of a write. It reads back zero-extended, and the other written bits are dropped.
- R10: If a message is accepted for a slot in the same cycle that software writes that slot's status, the acceptance wins: the slot ends busy, holding the new source.
- R11: A message for a CPU number not below NUM_CPU is refused. Writes to payload-word addresses have no effect. Reads of unmapped or misaligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Incoming bus message present |
| msg_cpu | input | CPU_W | Target CPU of the message |
| msg_src | input | SRC_W | Source ID of the message |
| msg_data0 | input | DATA_W | First payload word |
| msg_data1 | input | DATA_W | Second payload word |
| msg_accept | output | 1 | Message taken this cycle |
| msg_refuse | output | 1 | Message refused this cycle, sender retries |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | CPU_W | CPU receiving the post |
| post_vec | output | VEC_W | Vector posted |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | Access is a write |
| reg_cpu | input | CPU_W | Number of the CPU making the access |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |

## Verification
The bound checker watches the message handshake on every cycle. It checks that each valid message gets exactly one of accept or refuse, that every acceptance is followed by a post naming the same CPU, that a refusal never leads to a post, that every read request returns data one cycle later, and that reset leaves the outputs quiet. Where the stored data ends up, the status bit layout, alias selection, the effect of busy writes, vector truncation, and the outcome when an acceptance and a software write collide can only be shown by the bench scenarios. Those scenarios read the registers back after each stimulus.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_D0,
    K_D1,
    K_STAT,
    K_VEC
  } acc_kind_e;

  localparam int BUSY_POS   = 5;            // busy bit in the status word
  localparam int STAT_W     = BUSY_POS + 1;
  localparam int STRIDE_LSB = 3;            // 8-byte stride per CPU
  localparam int PAGE_LSB   = 8;            // 256-byte pages
  localparam int PAGE_W     = 3;

  localparam logic [PAGE_W-1:0] PG_D0    = 3'd0;
  localparam logic [PAGE_W-1:0] PG_D1    = 3'd1;
  localparam logic [PAGE_W-1:0] PG_ST    = 3'd2;
  localparam logic [PAGE_W-1:0] PG_ALIAS = 3'd3;
  localparam logic [PAGE_W-1:0] PG_VEC   = 3'd4;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 6,
  parameter int CPU_W   = 3,
  parameter int ADDR_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CPU_W-1:0]  req_cpu,
  output acc_kind_e         kind,
  output logic [CPU_W-1:0]  idx
);
  localparam int SLOT_W  = PAGE_LSB - STRIDE_LSB;
  localparam int TOP_LSB = PAGE_LSB + PAGE_W;

  logic [PAGE_W-1:0] page;
  logic [SLOT_W-1:0] slot;
  logic              aligned;
  logic              high_zero;
  logic              slot_ok;
  logic              self_ok;

  assign page    = addr[TOP_LSB-1:PAGE_LSB];
  assign slot    = addr[PAGE_LSB-1:STRIDE_LSB];
  assign aligned = (addr[STRIDE_LSB-1:0] == '0);
  assign slot_ok = (int'(slot) < NUM_CPU);
  assign self_ok = (int'(req_cpu) < NUM_CPU);

  generate
    if (ADDR_W > TOP_LSB) begin : g_hi
      assign high_zero = (addr[ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_nohi
      assign high_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    kind = K_NONE;
    idx  = slot[CPU_W-1:0];
    if (high_zero && aligned) begin
      case (page)
        PG_D0: if (slot_ok) kind = K_D0;
        PG_D1: if (slot_ok) kind = K_D1;
        PG_ST: if (slot_ok) kind = K_STAT;
        PG_ALIAS: begin
          idx = req_cpu;
          if (self_ok) begin
            if (slot == SLOT_W'(0))      kind = K_D0;
            else if (slot == SLOT_W'(1)) kind = K_D1;
            else if (slot == SLOT_W'(2)) kind = K_STAT;
          end
        end
        PG_VEC: if (slot == SLOT_W'(0)) kind = K_VEC;
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_slots.sv
module mbx_slots
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 6,
  parameter int CPU_W   = 3,
  parameter int SRC_W   = 5,
  parameter int VEC_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [CPU_W-1:0]  msg_cpu,
  input  logic [SRC_W-1:0]  msg_src,
  output logic              msg_accept,
  output logic              msg_refuse,
  input  logic              sw_we,
  input  logic [CPU_W-1:0]  sw_idx,
  input  logic              sw_busy,
  input  logic              vec_we,
  input  logic [VEC_W-1:0]  vec_wdata,
  input  logic              stat_rd,
  input  logic [CPU_W-1:0]  stat_idx,
  output logic [STAT_W-1:0] stat_q,
  output logic [VEC_W-1:0]  vec_q,
  output logic              post_valid,
  output logic [CPU_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec
);
  localparam int PAD_N = 2 ** CPU_W;

  logic [PAD_N-1:0]  busy_pad;
  logic [STAT_W-1:0] stat_w [PAD_N];

  // Slots beyond NUM_CPU look permanently busy, so their messages are refused.
  generate
    for (genvar i = 0; i < PAD_N; i++) begin : g_slot
      if (i < NUM_CPU) begin : g_live
        logic             busy_q;
        logic [SRC_W-1:0] src_q;
        logic             acc_hit;
        logic             sw_hit;

        assign acc_hit = msg_accept && (msg_cpu == CPU_W'(i));
        assign sw_hit  = sw_we && (sw_idx == CPU_W'(i));

        always_ff @(posedge clk) begin
          if (rst) begin
            busy_q <= 1'b0;
            src_q  <= '0;
          end else if (acc_hit) begin
            busy_q <= 1'b1;
            src_q  <= msg_src;
          end else if (sw_hit) begin
            busy_q <= sw_busy;
          end
        end

        assign busy_pad[i] = busy_q;
        assign stat_w[i]   = STAT_W'(src_q) | (STAT_W'(busy_q) << BUSY_POS);
      end else begin : g_pad
        assign busy_pad[i] = 1'b1;
        assign stat_w[i]   = '0;
      end
    end
  endgenerate

  assign msg_accept = msg_valid && !rst && !busy_pad[msg_cpu];
  assign msg_refuse = msg_valid && !rst &&  busy_pad[msg_cpu];

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '0;
    end else if (vec_we) begin
      vec_q <= vec_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (stat_rd) begin
      stat_q <= stat_w[stat_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else begin
      post_valid <= msg_accept;
      if (msg_accept) begin
        post_cpu <= msg_cpu;
        post_vec <= vec_q;
      end
    end
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DEPTH  = 6,
  parameter int AW     = 3,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  // Simple dual-port array, one write port and one registered read port.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cpu_msg_mailbox.sv
module cpu_msg_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 6,
  parameter int SRC_W   = 5,
  parameter int DATA_W  = 64,
  parameter int VEC_W   = 6,
  parameter int ADDR_W  = 12,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [CPU_W-1:0]  msg_cpu,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic [DATA_W-1:0] msg_data0,
  input  logic [DATA_W-1:0] msg_data1,
  output logic              msg_accept,
  output logic              msg_refuse,
  output logic              post_valid,
  output logic [CPU_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [CPU_W-1:0]  reg_cpu,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NWORDS = 2;

  acc_kind_e         kind;
  logic [CPU_W-1:0]  idx;
  logic              rd_go;
  logic              wr_go;
  logic [STAT_W-1:0] stat_q;
  logic [VEC_W-1:0]  vec_q;
  logic [VEC_W-1:0]  vec_rd_q;
  acc_kind_e         kind_q;
  logic [DATA_W-1:0] word_in  [NWORDS];
  logic [DATA_W-1:0] word_out [NWORDS];
  acc_kind_e         word_kind [NWORDS];

  assign rd_go = reg_req && !reg_we;
  assign wr_go = reg_req &&  reg_we;

  mbx_decode #(
    .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(reg_addr), .req_cpu(reg_cpu), .kind(kind), .idx(idx)
  );

  mbx_slots #(
    .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .SRC_W(SRC_W), .VEC_W(VEC_W)
  ) u_slots (
    .clk(clk), .rst(rst),
    .msg_valid(msg_valid), .msg_cpu(msg_cpu), .msg_src(msg_src),
    .msg_accept(msg_accept), .msg_refuse(msg_refuse),
    .sw_we(wr_go && kind == K_STAT), .sw_idx(idx),
    .sw_busy(reg_wdata[BUSY_POS]),
    .vec_we(wr_go && kind == K_VEC), .vec_wdata(reg_wdata[VEC_W-1:0]),
    .stat_rd(rd_go && kind == K_STAT), .stat_idx(idx), .stat_q(stat_q),
    .vec_q(vec_q),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
  );

  assign word_in[0]   = msg_data0;
  assign word_in[1]   = msg_data1;
  assign word_kind[0] = K_D0;
  assign word_kind[1] = K_D1;

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      mbx_store #(
        .DEPTH(NUM_CPU), .AW(CPU_W), .DATA_W(DATA_W)
      ) u_ram (
        .clk(clk),
        .we(msg_accept), .waddr(msg_cpu), .wdata(word_in[w]),
        .re(rd_go && kind == word_kind[w]), .raddr(idx),
        .rdata(word_out[w])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      kind_q   <= K_NONE;
      vec_rd_q <= '0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) begin
        kind_q   <= kind;
        vec_rd_q <= vec_q;
      end
    end
  end

  always_comb begin
    case (kind_q)
      K_D0:    rd_data = word_out[0];
      K_D1:    rd_data = word_out[1];
      K_STAT:  rd_data = DATA_W'(stat_q);
      K_VEC:   rd_data = DATA_W'(vec_rd_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int CPU_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_valid,
  input logic [CPU_W-1:0] msg_cpu,
  input logic             msg_accept,
  input logic             msg_refuse,
  input logic             post_valid,
  input logic [CPU_W-1:0] post_cpu,
  input logic             reg_req,
  input logic             reg_we,
  input logic             rd_valid
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!post_valid && !rd_valid));

  // R2
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_accept != msg_refuse));

  // R2
  no_answer_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !msg_valid |-> (!msg_accept && !msg_refuse));

  // R4
  post_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    msg_accept |=> (post_valid && post_cpu == $past(msg_cpu)));

  // R3
  refuse_no_post_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_refuse || !msg_valid) |=> !post_valid);

  // R5
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_we) |=> rd_valid);

  // R5
  no_spurious_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_req && !reg_we) |=> !rd_valid);
endmodule

bind cpu_msg_mailbox mbx_chk #(.CPU_W(CPU_W)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_cpu(msg_cpu),
  .msg_accept(msg_accept), .msg_refuse(msg_refuse),
  .post_valid(post_valid), .post_cpu(post_cpu),
  .reg_req(reg_req), .reg_we(reg_we), .rd_valid(rd_valid)
);

// File: tb/sim_cpu_msg_mailbox.sv
`timescale 1ns/1ps
module sim_cpu_msg_mailbox;
  localparam int NUM_CPU = 6;
  localparam int CPU_W   = 3;
  localparam int SRC_W   = 5;
  localparam int DATA_W  = 64;
  localparam int VEC_W   = 6;
  localparam int ADDR_W  = 12;
  localparam int NTBL    = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              msg_valid = 1'b0;
  logic [CPU_W-1:0]  msg_cpu = '0;
  logic [SRC_W-1:0]  msg_src = '0;
  logic [DATA_W-1:0] msg_data0 = '0;
  logic [DATA_W-1:0] msg_data1 = '0;
  logic              msg_accept, msg_refuse, post_valid, rd_valid;
  logic [CPU_W-1:0]  post_cpu;
  logic [VEC_W-1:0]  post_vec;
  logic              reg_req = 1'b0;
  logic              reg_we = 1'b0;
  logic [CPU_W-1:0]  reg_cpu = '0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] rd_data;

  int n_run = 0;
  int n_fail = 0;

  logic             m_busy [NUM_CPU];
  logic [SRC_W-1:0] m_src  [NUM_CPU];
  logic [DATA_W-1:0] m_d0  [NUM_CPU];
  logic [DATA_W-1:0] m_d1  [NUM_CPU];
  logic [VEC_W-1:0] m_vec;

  // Entry: {op(1: free slot), cpu(3), src(5), seed(8), expect_accept(1)}
  localparam logic [17:0] TBL [NTBL] = '{
    {1'b0, 3'd0, 5'd3,  8'h11, 1'b1},
    {1'b0, 3'd1, 5'd7,  8'h22, 1'b1},
    {1'b0, 3'd0, 5'd9,  8'h33, 1'b0},
    {1'b0, 3'd5, 5'd31, 8'h44, 1'b1},
    {1'b0, 3'd6, 5'd1,  8'h55, 1'b0},
    {1'b0, 3'd7, 5'd1,  8'h56, 1'b0},
    {1'b1, 3'd0, 5'd0,  8'h00, 1'b0},
    {1'b0, 3'd0, 5'd12, 8'h66, 1'b1},
    {1'b0, 3'd1, 5'd2,  8'h77, 1'b0},
    {1'b1, 3'd1, 5'd0,  8'h00, 1'b0},
    {1'b0, 3'd1, 5'd4,  8'h88, 1'b1}
  };

  cpu_msg_mailbox #(
    .NUM_CPU(NUM_CPU), .SRC_W(SRC_W), .DATA_W(DATA_W),
    .VEC_W(VEC_W), .ADDR_W(ADDR_W)
  ) u0 (.*);

  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] pat0(input logic [7:0] s);
    return {8{s}};
  endfunction
  function automatic logic [DATA_W-1:0] pat1(input logic [7:0] s);
    return ~{8{s}} ^ 64'h1;
  endfunction
  function automatic logic [DATA_W-1:0] stat_of(input logic b, input logic [SRC_W-1:0] s);
    return (DATA_W'(b) << 5) | DATA_W'(s);
  endfunction
  function automatic logic [ADDR_W-1:0] a_d0(input int i);  return ADDR_W'(12'h000 + 8*i); endfunction
  function automatic logic [ADDR_W-1:0] a_d1(input int i);  return ADDR_W'(12'h100 + 8*i); endfunction
  function automatic logic [ADDR_W-1:0] a_st(input int i);  return ADDR_W'(12'h200 + 8*i); endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [CPU_W-1:0] c, input logic [SRC_W-1:0] s,
                      input logic [7:0] seed, input logic exp_acc);
    @(negedge clk);
    msg_valid = 1'b1; msg_cpu = c; msg_src = s;
    msg_data0 = pat0(seed); msg_data1 = pat1(seed);
    #1;
    chk(exp_acc ? "R2 accept" : "R3 refuse", {63'b0, msg_accept}, {63'b0, exp_acc});
    chk(exp_acc ? "R2 no-refuse" : "R3 refuse flag", {63'b0, msg_refuse}, {63'b0, !exp_acc});
    @(negedge clk);
    msg_valid = 1'b0;
    chk("R4 post strobe", {63'b0, post_valid}, {63'b0, exp_acc});
    if (exp_acc) begin
      chk("R4 post cpu", DATA_W'(post_cpu), DATA_W'(c));
      chk("R4 post vector", DATA_W'(post_vec), DATA_W'(m_vec));
      m_busy[c] = 1'b1; m_src[c] = s; m_d0[c] = pat0(seed); m_d1[c] = pat1(seed);
    end
  endtask

  task automatic rd(input string req, input logic [ADDR_W-1:0] a,
                    input logic [CPU_W-1:0] who, input logic [DATA_W-1:0] exp);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a; reg_cpu = who;
    @(negedge clk);
    reg_req = 1'b0;
    chk({req, " rd_valid"}, {63'b0, rd_valid}, 64'd1);
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [CPU_W-1:0] who,
                    input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_cpu = who; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_CPU; i++) begin
      m_busy[i] = 1'b0; m_src[i] = '0; m_d0[i] = '0; m_d1[i] = '0;
    end
    m_vec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 post_valid in reset", {63'b0, post_valid}, 64'd0);
    chk("R1 rd_valid in reset", {63'b0, rd_valid}, 64'd0);
    rst = 1'b0;
    for (int i = 0; i < NUM_CPU; i++) rd("R1 status after reset", a_st(i), '0, '0);
    rd("R1 vector after reset", 12'h400, '0, '0);

    // R9: only bits 5:0 of the vector write are kept
    wr(12'h400, '0, 64'hFFFF_FFFF_FFFF_FFEA);
    m_vec = 6'h2A;
    rd("R9 vector readback", 12'h400, '0, 64'h2A);

    // Vector table: messages and slot frees
    for (int k = 0; k < NTBL; k++) begin
      logic [17:0] e;
      e = TBL[k];
      if (e[17]) begin
        wr(a_st(int'(e[16:14])), '0, 64'h0);   // R8 free slot
        m_busy[e[16:14]] = 1'b0;
      end else begin
        send(e[16:14], e[13:9], e[8:1], e[0]);
      end
    end

    // R5 R6: indexed status and data words against the model
    for (int i = 0; i < NUM_CPU; i++) begin
      rd("R5 status format", a_st(i), '0, stat_of(m_busy[i], m_src[i]));
      if (m_busy[i]) begin
        rd("R6 data0 indexed", a_d0(i), '0, m_d0[i]);
        rd("R6 data1 indexed", a_d1(i), '0, m_d1[i]);
      end
    end
    // R3: refused message for busy cpu0 (seed 33) left nothing behind
    rd("R3 no store on refuse", a_d0(0), '0, pat0(8'h66));

    // R7: alias registers follow reg_cpu
    rd("R7 alias data0", 12'h300, 3'd5, pat0(8'h44));
    rd("R7 alias data1", 12'h308, 3'd5, pat1(8'h44));
    rd("R7 alias status", 12'h310, 3'd5, stat_of(1'b1, 5'd31));
    rd("R7 alias status free slot", 12'h310, 3'd2, 64'h0);

    // R8: occupy free slot 2 via alias, source kept, messages refused
    wr(12'h310, 3'd2, 64'h20);
    rd("R8 alias busy write", a_st(2), '0, stat_of(1'b1, 5'd0));
    send(3'd2, 5'd6, 8'h99, 1'b0);
    wr(12'h310, 3'd5, 64'hFFFF_FFFF_FFFF_FFDF);   // bit 5 clear frees cpu5
    rd("R8 free keeps source", a_st(5), '0, stat_of(1'b0, 5'd31));

    // R10: acceptance beats a same-cycle status write to that slot
    @(negedge clk);
    msg_valid = 1'b1; msg_cpu = 3'd3; msg_src = 5'd17;
    msg_data0 = pat0(8'hAB); msg_data1 = pat1(8'hAB);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a_st(3); reg_wdata = 64'h0;
    #1;
    chk("R10 accept during write", {63'b0, msg_accept}, 64'd1);
    @(negedge clk);
    msg_valid = 1'b0; reg_req = 1'b0; reg_we = 1'b0;
    rd("R10 slot busy after collision", a_st(3), '0, stat_of(1'b1, 5'd17));

    // R11: writes to data words ignored; unmapped or misaligned reads are 0
    wr(a_d0(3), '0, 64'hDEAD_BEEF_0000_1111);
    rd("R11 data write ignored", a_d0(3), '0, pat0(8'hAB));
    rd("R11 unmapped read", 12'h500, '0, 64'h0);
    rd("R11 misaligned read", 12'h204, '0, 64'h0);
    rd("R11 index beyond cpus", a_st(6), '0, 64'h0);

    // R1: reset in mid-run clears slots and vector
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd("R1 status after second reset", a_st(1), '0, 64'h0);
    rd("R1 vector after second reset", 12'h400, '0, 64'h0);
    m_vec = '0;
    send(3'd1, 5'd8, 8'h5A, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule